// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects four interrupt sources for a small processor core. Two sources are external pins with selectable triggering. Two are overflow strobes from timers that sit outside the block. Each source has a pending flag. A source requests service when its flag is set, its own enable is set and the global enable is set. The controller picks one request and presents it to the core as a vector address. Any source can be made high or low priority, and a fixed order breaks ties within a level.

The vectored request uses a valid/ready handshake. `irq_valid_o` means a request is offered, and `irq_ready_i` is the core's acknowledge. A transfer happens on a clock edge where both are high. The offer is a live view of the pending sources: while `irq_ready_i` is low, the vector may change or the offer may be withdrawn. The core must use the vector that is present in the transfer cycle. A transfer has three effects: it clears the edge flag of an external source that was granted, it marks that priority level as in service, and it leaves timer flags alone.

The block tracks which priority levels are in service. While a high-priority service is active, no request is offered. While only a low-priority service is active, only high-priority requests are offered. A return strobe from the core ends the innermost active service.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the global enable, the source enables, the priority bits and the trigger-mode bits are 0. All pending flags are 0, `in_svc_o` is 0 and `irq_valid_o` is 0.
- R2: While the global enable (select 0, bit 0) is 0, `irq_valid_o` stays 0 whatever the flags and source enables are.
- R3: A source offers a request only while its enable bit (select 1) is 1. Source index order is: 0 = external pin 0, 1 = timer 0, 2 = external pin 1, 3 = timer 1.
- R4: With its mode bit at 1 (select 3: bit 0 for pin 0, bit 1 for pin 1), an external pin sets its flag on a falling edge. The flag becomes visible on the third rising clock edge after the pin changes. A rising edge or a steady level sets nothing.
- R5: With its mode bit at 0, an external flag follows the inverted pin with the same three-edge latency. A low pin requests service and a high pin does not.
- R6: A transfer that grants an edge-mode external source clears that source's flag. A transfer that grants a timer source leaves its flag set.
- R7: A timer flag is set by a one-cycle pulse on `tmr_ovf_i`. It is cleared only by writing 1 to its bit at select 4, which clears bits where a 1 is written.
- R8: Any offered high-priority request (priority bit = 1, select 2) wins over every low-priority request, and `irq_level_o` gives the level of the offered request.
- R9: Among requests of the same level, the lowest source index wins.
- R10: The offered vector equals 0x0003 + 8 × source index: 0x0003, 0x000B, 0x0013 or 0x001B.
- R11: While the high level is in service (`in_svc_o[1]`), nothing is offered. While only the low level is in service (`in_svc_o[0]`), only high-priority requests are offered.
- R12: A pulse on `reti_i` clears `in_svc_o[1]` if it is set. Otherwise it clears `in_svc_o[0]`.
- R13: While `irq_valid_o` is high and `irq_ready_i` is low, the in-service state and the flags are not changed by the pending offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin_i | input | 2 | External interrupt pins, idle high, asynchronous |
| tmr_ovf_i | input | 2 | Timer overflow pulses (bit 0 timer 0, bit 1 timer 1) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select: 0 global, 1 enables, 2 priority, 3 trigger mode, 4 flag clear |
| wr_data_i | input | 4 | Write data, one bit per source index |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_valid_o | output | 1 | Interrupt request offered |
| irq_ready_i | input | 1 | Core acknowledge; transfer when valid and ready |
| irq_vector_o | output | 16 | Vector address of the offered request |
| irq_level_o | output | 1 | Level of the offered request (1 = high) |
| flags_o | output | 4 | Pending flags by source index |
| in_svc_o | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
The embedded assertions check a set of rules on every cycle. No offer is made without the global enable or during a high-level service. A granted external edge flag drops after the transfer. A timer flag changes only by a pulse or by a clear write. A return pops the innermost level. Every offered vector sits on the 8-byte grid, and a waiting offer leaves the in-service state untouched. Some behaviours can only be shown by the bench's directed scenarios: the exact three-edge pin latency, the winner among mixed priorities, the tie order, pre-emption of a low service by a high request, and the sequence of nested returns.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    SEL_GLB    = 3'd0,
    SEL_SRC_EN = 3'd1,
    SEL_PRIO   = 3'd2,
    SEL_MODE   = 3'd3,
    SEL_CLR    = 3'd4
  } reg_sel_e;

  localparam int LVL_N = 2;

  typedef struct packed {
    logic hi;
    logic lo;
  } svc_t;
endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic edge_mode_i,
  input  logic ack_i,
  input  logic sw_clr_i,
  output logic flag_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic flag_q;
  logic cur;
  logic fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= cur;
    end
  end

  assign cur  = sync_q[SYNC_STAGES-1];
  assign fall = prev_q & ~cur;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (!edge_mode_i) flag_q <= ~cur;
    else if (fall) flag_q <= 1'b1;
    else if (ack_i || sw_clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R6
  ack_clears_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && ack_i && !fall) |=> !flag_q);

  // R4
  edge_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && !fall && !flag_q) |=> !flag_q);
endmodule

// File: rtl/irq_timer_flags.sv
module irq_timer_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R7
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
    // R7
    tmr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[i] && !set_i[i]) |=> !flag_q[i]);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int SRC_N      = 4,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] req_i,
  input  logic [SRC_N-1:0] hi_i,
  input  logic             allow_hi_i,
  input  logic             allow_lo_i,
  output logic             valid_o,
  output logic             level_o,
  output logic [SRC_N-1:0] grant_o,
  output logic [VEC_W-1:0] vector_o
);
  localparam int IDX_W = (SRC_N > 1) ? $clog2(SRC_N) : 1;

  logic [SRC_N-1:0] hi_req, lo_req, pick;
  logic [IDX_W-1:0] idx;

  assign hi_req = req_i & hi_i & {SRC_N{allow_hi_i}};
  assign lo_req = req_i & ~hi_i & {SRC_N{allow_lo_i}};
  assign level_o = |hi_req;
  assign pick = level_o ? hi_req : lo_req;
  assign valid_o = |pick;

  always_comb begin
    idx = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (pick[i]) idx = IDX_W'(i);
    end
  end

  assign grant_o  = valid_o ? (SRC_N'(1) << idx) : '0;
  assign vector_o = VEC_W'(VEC_BASE + int'(idx) * VEC_STRIDE);

  // R8
  grant_is_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($onehot(grant_o) && ((grant_o & ~req_i) == '0)));

  // R9
  lowest_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (((grant_o - SRC_N'(1)) & req_i & (level_o ? hi_i : ~hi_i)) == '0));
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic accept_hi_i,
  input  logic reti_i,
  output svc_t svc_o,
  output logic allow_hi_o,
  output logic allow_lo_o
);
  svc_t svc_q, svc_d;

  always_comb begin
    svc_d = svc_q;
    if (reti_i) begin
      if (svc_d.hi) svc_d.hi = 1'b0;
      else svc_d.lo = 1'b0;
    end
    if (accept_i) begin
      if (accept_hi_i) svc_d.hi = 1'b1;
      else svc_d.lo = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) svc_q <= '0;
    else svc_q <= svc_d;
  end

  assign svc_o      = svc_q;
  assign allow_hi_o = ~svc_q.hi;
  assign allow_lo_o = ~svc_q.hi & ~svc_q.lo;

  // R12
  reti_pops_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !accept_i && svc_q.hi) |=> (!svc_q.hi && $stable(svc_q.lo)));

  // R12
  reti_pops_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !accept_i && !svc_q.hi) |=> !svc_q.lo);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_PAIRS   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 16,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PAIRS-1:0]   ext_pin_i,
  input  logic [NUM_PAIRS-1:0]   tmr_ovf_i,
  input  logic                   wr_en_i,
  input  logic [2:0]             wr_sel_i,
  input  logic [2*NUM_PAIRS-1:0] wr_data_i,
  input  logic                   reti_i,
  output logic                   irq_valid_o,
  input  logic                   irq_ready_i,
  output logic [VEC_W-1:0]       irq_vector_o,
  output logic                   irq_level_o,
  output logic [2*NUM_PAIRS-1:0] flags_o,
  output logic [LVL_N-1:0]       in_svc_o
);
  localparam int SRC_N = 2 * NUM_PAIRS;

  logic                 glb_en_q;
  logic [SRC_N-1:0]     src_en_q, src_hi_q;
  logic [NUM_PAIRS-1:0] ext_edge_q;
  logic [SRC_N-1:0]     clr_bits, req, grant, flags;
  logic [NUM_PAIRS-1:0] tmr_clr, tmr_flags;
  logic                 accept, allow_hi, allow_lo;
  svc_t                 svc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_en_q   <= 1'b0;
      src_en_q   <= '0;
      src_hi_q   <= '0;
      ext_edge_q <= '0;
    end else if (wr_en_i) begin
      case (reg_sel_e'(wr_sel_i))
        SEL_GLB:    glb_en_q   <= wr_data_i[0];
        SEL_SRC_EN: src_en_q   <= wr_data_i;
        SEL_PRIO:   src_hi_q   <= wr_data_i;
        SEL_MODE:   ext_edge_q <= wr_data_i[NUM_PAIRS-1:0];
        default: ;
      endcase
    end
  end

  assign clr_bits = (wr_en_i && reg_sel_e'(wr_sel_i) == SEL_CLR) ? wr_data_i : '0;
  assign accept   = irq_valid_o & irq_ready_i;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    irq_pin_detect #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (ext_pin_i[k]),
      .edge_mode_i (ext_edge_q[k]),
      .ack_i       (accept & grant[2*k]),
      .sw_clr_i    (clr_bits[2*k]),
      .flag_o      (flags[2*k])
    );
    assign tmr_clr[k]     = clr_bits[2*k+1];
    assign flags[2*k+1]   = tmr_flags[k];
  end

  irq_timer_flags #(.N(NUM_PAIRS)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (tmr_ovf_i),
    .clr_i  (tmr_clr),
    .flag_o (tmr_flags)
  );

  assign req = flags & src_en_q & {SRC_N{glb_en_q}};

  irq_arbiter #(
    .SRC_N(SRC_N), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .hi_i       (src_hi_q),
    .allow_hi_i (allow_hi),
    .allow_lo_i (allow_lo),
    .valid_o    (irq_valid_o),
    .level_o    (irq_level_o),
    .grant_o    (grant),
    .vector_o   (irq_vector_o)
  );

  irq_svc_track u_svc (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .accept_hi_i (irq_level_o),
    .reti_i      (reti_i),
    .svc_o       (svc),
    .allow_hi_o  (allow_hi),
    .allow_lo_o  (allow_lo)
  );

  assign flags_o  = flags;
  assign in_svc_o = {svc.hi, svc.lo};

  // R2
  glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_q |-> !irq_valid_o);

  // R11
  hi_svc_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc.hi |-> !irq_valid_o);

  // R11
  lo_svc_only_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc.lo && irq_valid_o) |-> irq_level_o);

  // R10
  vector_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> ((int'(irq_vector_o) - VEC_BASE) % VEC_STRIDE == 0
                     && int'(irq_vector_o) < VEC_BASE + SRC_N * VEC_STRIDE));

  // R13
  wait_keeps_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && !irq_ready_i && !reti_i) |=> $stable(in_svc_o));
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext_pin = 2'b11;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [3:0]  wr_data = 4'd0;
  logic        reti = 1'b0;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [15:0] irq_vector;
  logic        irq_level;
  logic [3:0]  flags;
  logic [1:0]  in_svc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .tmr_ovf_i(tmr_ovf),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .reti_i(reti),
    .irq_valid_o(irq_valid), .irq_ready_i(irq_ready), .irq_vector_o(irq_vector),
    .irq_level_o(irq_level), .flags_o(flags), .in_svc_o(in_svc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [3:0] data);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_ovf(input logic [1:0] bits);
    @(negedge clk); tmr_ovf = bits;
    @(negedge clk); tmr_ovf = 2'b00;
  endtask

  task automatic take();
    @(negedge clk); irq_ready = 1'b1;
    @(negedge clk); irq_ready = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid", irq_valid, 0);
    chk("R1 flags", flags, 0);
    chk("R1 in_svc", in_svc, 0);
    pulse_ovf(2'b01);
    chk("R1 enables zero so no request", irq_valid, 0);
    wr(3'd4, 4'b0010);
  endtask

  task automatic t_timer();
    pulse_ovf(2'b01);
    chk("R7 timer0 flag set", flags[1], 1);
    wr(3'd1, 4'b0010);
    chk("R2 global off", irq_valid, 0);
    wr(3'd0, 4'b0001);
    chk("R3 enabled valid", irq_valid, 1);
    chk("R10 timer0 vector", irq_vector, 16'h000B);
    wr(3'd1, 4'b0000);
    chk("R3 disabled source", irq_valid, 0);
    wr(3'd1, 4'b0010);
    take();
    chk("R6 timer flag kept", flags[1], 1);
    chk("R11 low in service", in_svc, 2'b01);
    chk("R11 low blocks low", irq_valid, 0);
    ret();
    chk("R12 lo released", in_svc, 2'b00);
    wr(3'd4, 4'b0010);
    chk("R7 W1C clears", flags[1], 0);
  endtask

  task automatic t_edge();
    wr(3'd3, 4'b0001);
    wr(3'd1, 4'b0011);
    @(negedge clk); ext_pin[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R4 not yet after two edges", flags[0], 0);
    @(negedge clk);
    chk("R4 set on third edge", flags[0], 1);
    @(negedge clk); ext_pin[0] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 latched after pin rises", flags[0], 1);
    chk("R10 ext0 vector", irq_vector, 16'h0003);
    take();
    chk("R6 edge flag cleared on accept", flags[0], 0);
    ret();
    repeat (4) @(negedge clk);
    chk("R4 rising edge sets nothing", flags[0], 0);
  endtask

  task automatic t_level();
    wr(3'd1, 4'b0100);
    @(negedge clk); ext_pin[1] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 low level flag", flags[2], 1);
    chk("R10 ext1 vector", irq_vector, 16'h0013);
    @(negedge clk); ext_pin[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R5 still set two edges later", flags[2], 1);
    @(negedge clk);
    chk("R5 follows high pin", flags[2], 0);
    chk("R5 no request", irq_valid, 0);
  endtask

  task automatic t_prio();
    @(negedge clk); ext_pin[1] = 1'b0;
    pulse_ovf(2'b11);
    wr(3'd1, 4'b1111);
    wr(3'd2, 4'b0000);
    chk("R9 tie lowest index", irq_vector, 16'h000B);
    chk("R9 level low", irq_level, 0);
    wr(3'd2, 4'b1000);
    chk("R8 high wins", irq_vector, 16'h001B);
    chk("R8 level high", irq_level, 1);
    wr(3'd2, 4'b1100);
    chk("R9 tie among high", irq_vector, 16'h0013);
    wr(3'd2, 4'b0000);
    take();
    chk("R11 low active", in_svc, 2'b01);
    chk("R11 low blocks low", irq_valid, 0);
    wr(3'd2, 4'b1000);
    chk("R11 high pre-empts", irq_valid, 1);
    chk("R11 pre-empt vector", irq_vector, 16'h001B);
    repeat (3) @(negedge clk);
    chk("R13 waiting keeps svc", in_svc, 2'b01);
    chk("R13 waiting keeps flags", flags, 4'b1110);
    take();
    chk("R11 both levels", in_svc, 2'b11);
    chk("R11 high blocks all", irq_valid, 0);
    ret();
    chk("R12 high popped first", in_svc, 2'b01);
    chk("R12 high request returns", irq_vector, 16'h001B);
    ret();
    chk("R12 all released", in_svc, 2'b00);
    wr(3'd0, 4'b0000);
    chk("R2 global cleared", irq_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timer();
    t_edge();
    t_level();
    t_prio();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule